// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block holds six independent clock-enable generators behind two 32-bit control words. Each generator watches one of three fast source strobes (a CPU-clock strobe and two auxiliary PLL strobes), counts the strobes of the one it has selected, and emits a single-cycle tick once it has counted the programmed ratio. Downstream logic uses each tick as a clock enable at the divided rate. No real clock is produced or switched; everything runs in the one system clock domain.

Every generator owns a 10-bit field. The field's upper eight bits hold a divider value D and its lower two bits choose the source. A static mode pin selects between two field meanings. In the legacy layout one bit picks the source and the other bit enables the output. In the extended layout the two bits form a source code, and code zero turns the generator off. Only in the extended layout, a per-word scale bit changes the divider from even steps to unit steps.

Top module: `fgen_bank`

## Requirements
- R1: After reset both control words read 0x00000000 and every tick output is low.
- R2: A write with `wr_en` high stores bits 30..0 of `wr_data` into the word chosen by `wr_addr` (0 or 1). Bit 31 always reads 0. `rd_data` shows the word chosen by `rd_addr` from the cycle after the write.
- R3: Generator n takes its field from word n/3 (integer division), at bit offset 10*(n mod 3). Field bits [9:2] are D and field bits [1:0] are the source code.
- R4: With `ext_mode` low, field bit 1 enables the generator. Field bit 0 selects the source: 0 for `src_cpu`, 1 for `src_aux`.
- R5: With `ext_mode` low, an enabled generator ticks once for every (D+1)*2 strobes of its selected source. This covers ratios from 2 to 512, and the scale bit is ignored.
- R6: With `ext_mode` high, source code 0 disables the generator. Code 1 selects `src_aux2`, code 2 selects `src_cpu` and code 3 selects `src_aux`.
- R7: With `ext_mode` high, bit 30 of a word sets the ratio of its three generators. When the bit is 1 the ratio is D+1 (1 to 256). When it is 0 the ratio is (D+1)*2.
- R8: A write to a word restarts the strobe count of that word's three generators from zero, and none of them ticks in the following cycle. The next tick comes after a full ratio of strobes under the new setting.
- R9: A disabled generator keeps its tick low and its count at zero. After it is enabled again, its first tick needs a full ratio of strobes.
- R10: A tick is high for exactly one cycle. It appears in the cycle after the clock edge that sampled the strobe completing the ratio. Strobes on sources that are not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | 0 selects the legacy field layout, 1 the extended layout |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | 1 | Index of the control word to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Index of the control word to read |
| rd_data | output | 32 | Contents of the addressed control word |
| src_cpu | input | 1 | CPU-clock source strobe |
| src_aux | input | 1 | First auxiliary PLL source strobe |
| src_aux2 | input | 1 | Second auxiliary PLL source strobe |
| gen_tick | output | 6 | One tick output per generator |

## Verification
The bench builds the block with its default parameters: two control words of 32 bits, three generators per word and an 8-bit divider. This brings in both ends of the divider range, D=0 and D=255, which give ratios of 1, 2, 256 and 512. Random strobes at 70 percent density drive all three sources at once. A behavioural model, compared every cycle, therefore shows whether unselected strobes leak through. Timed rewrites, disable and re-enable, and a switch between the two layouts exercise the count restart and the hold at zero.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

  localparam int FG_DIV_W = 8;
  localparam int FG_CNT_W = FG_DIV_W + 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_AUX  = 2'd2,
    SRC_AUX2 = 2'd3
  } src_e;

  // Highest count value before a tick: ratio minus one.
  // Unit steps: ratio D+1 -> D. Even steps: ratio 2D+2 -> 2D+1.
  function automatic logic [FG_CNT_W-1:0] fg_last(input logic [FG_DIV_W-1:0] d,
                                                  input logic unit_step);
    if (unit_step) return {1'b0, d};
    return {d, 1'b1};
  endfunction

  // Turns the two low field bits into a source choice for either layout.
  function automatic src_e fg_decode(input logic ext, input logic [1:0] code);
    if (ext) begin
      case (code)
        2'd1:    return SRC_AUX2;
        2'd2:    return SRC_CPU;
        2'd3:    return SRC_AUX;
        default: return SRC_NONE;
      endcase
    end
    if (!code[1]) return SRC_NONE;
    return code[0] ? SRC_AUX : SRC_CPU;
  endfunction

endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
  parameter int NUM_REG     = 2,
  parameter int REG_W       = 32,
  parameter int FIELD_BITS  = 30,
  parameter int SCALE_BIT   = 30,
  localparam int SEL_W      = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_addr,
  input  logic [REG_W-1:0]                wr_data,
  input  logic [SEL_W-1:0]                rd_addr,
  output logic [REG_W-1:0]                rd_data,
  output logic [NUM_REG-1:0][REG_W-1:0]   ctrl_q,
  output logic [NUM_REG-1:0]              wr_hit
);

  localparam logic [REG_W-1:0] KEEP_MASK =
    ((REG_W'(1) << FIELD_BITS) - REG_W'(1)) | (REG_W'(1) << SCALE_BIT);

  always_comb begin
    for (int r = 0; r < NUM_REG; r++) begin
      wr_hit[r] = wr_en && (wr_addr == SEL_W'(r));
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[r] <= '0;
      end else if (wr_hit[r]) begin
        ctrl_q[r] <= wr_data & KEEP_MASK;
      end
    end
  end

  assign rd_data = ctrl_q[rd_addr];

endmodule

// File: rtl/fgen_div.sv
module fgen_div #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             on,
  input  logic             hit,
  input  logic [CNT_W-1:0] last,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  // ">=" keeps a count that overshoots a shrunken ratio from running away.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr || !on) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (hit) begin
      if (cnt >= last) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + CNT_W'(1);
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/fgen_bank.sv
module fgen_bank #(
  parameter int NUM_REG      = 2,
  parameter int GEN_PER_REG  = 3,
  parameter int REG_W        = 32,
  parameter int SCALE_BIT    = 30,
  localparam int NUM_GEN     = NUM_REG * GEN_PER_REG,
  localparam int SEL_W       = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_mode,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [SEL_W-1:0]   rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic               src_cpu,
  input  logic               src_aux,
  input  logic               src_aux2,
  output logic [NUM_GEN-1:0] gen_tick
);
  import fgen_pkg::*;

  localparam int DIV_W      = FG_DIV_W;
  localparam int CNT_W      = FG_CNT_W;
  localparam int FIELD_W    = DIV_W + 2;
  localparam int FIELD_BITS = GEN_PER_REG * FIELD_W;

  logic [NUM_REG-1:0][REG_W-1:0] ctrl_q;
  logic [NUM_REG-1:0]            wr_hit;

  // Named per-generator events, observed by the checker.
  logic [NUM_GEN-1:0] gen_on;
  logic [NUM_GEN-1:0] src_hit;
  logic [NUM_GEN-1:0] cnt_clr;
  logic [NUM_GEN-1:0] ratio_one;

  fgen_regs #(
    .NUM_REG    (NUM_REG),
    .REG_W      (REG_W),
    .FIELD_BITS (FIELD_BITS),
    .SCALE_BIT  (SCALE_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_q),
    .wr_hit  (wr_hit)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int WORD = g / GEN_PER_REG;
    localparam int OFF  = (g % GEN_PER_REG) * FIELD_W;

    logic [FIELD_W-1:0] field;
    logic [DIV_W-1:0]   div_val;
    logic               unit_step;
    logic [CNT_W-1:0]   last;
    src_e               sel;

    assign field     = ctrl_q[WORD][OFF +: FIELD_W];
    assign div_val   = field[FIELD_W-1:2];
    assign sel       = fg_decode(ext_mode, field[1:0]);
    assign unit_step = ext_mode & ctrl_q[WORD][SCALE_BIT];
    assign last      = fg_last(div_val, unit_step);

    assign gen_on[g]    = (sel != SRC_NONE);
    assign cnt_clr[g]   = wr_hit[WORD];
    assign ratio_one[g] = (last == '0);

    always_comb begin
      case (sel)
        SRC_CPU:  src_hit[g] = src_cpu;
        SRC_AUX:  src_hit[g] = src_aux;
        SRC_AUX2: src_hit[g] = src_aux2;
        default:  src_hit[g] = 1'b0;
      endcase
    end

    fgen_div #(.CNT_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr[g]),
      .on    (gen_on[g]),
      .hit   (src_hit[g]),
      .last  (last),
      .tick  (gen_tick[g])
    );
  end

endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
  parameter int NUM_GEN = 6,
  parameter int NUM_REG = 2,
  parameter int REG_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [NUM_GEN-1:0]            gen_tick,
  input logic [NUM_GEN-1:0]            gen_on,
  input logic [NUM_GEN-1:0]            src_hit,
  input logic [NUM_GEN-1:0]            cnt_clr,
  input logic [NUM_GEN-1:0]            ratio_one,
  input logic [NUM_REG-1:0][REG_W-1:0] ctrl_q
);

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R9
    tick_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_tick[g] |-> $past(gen_on[g]));

    // R10
    tick_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_tick[g] |-> $past(src_hit[g]));

    // R8
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr[g] |=> !gen_tick[g]);

    // R7
    unit_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_on[g] && src_hit[g] && ratio_one[g] && !cnt_clr[g]) |=> gen_tick[g]);
  end

endmodule

bind fgen_bank fgen_bank_chk #(
  .NUM_GEN (NUM_GEN),
  .NUM_REG (NUM_REG),
  .REG_W   (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .gen_tick  (gen_tick),
  .gen_on    (gen_on),
  .src_hit   (src_hit),
  .cnt_clr   (cnt_clr),
  .ratio_one (ratio_one),
  .ctrl_q    (ctrl_q)
);

// File: tb/tb_fgen_bank.sv
module tb_fgen_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        src_cpu = 1'b0;
  logic        src_aux = 1'b0;
  logic        src_aux2 = 1'b0;
  logic [5:0]  gen_tick;

  int    checks = 0;
  int    errors = 0;
  int    dens   = 70;
  bit    done   = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  fgen_bank dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_mode (ext_mode),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .src_cpu  (src_cpu),
    .src_aux  (src_aux),
    .src_aux2 (src_aux2),
    .gen_tick (gen_tick)
  );

  // Behavioural reference model, restated from the requirements.
  logic [31:0] m_reg [2] = '{32'h0, 32'h0};
  int          m_cnt [6] = '{0, 0, 0, 0, 0, 0};
  bit          m_tick[6] = '{0, 0, 0, 0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 6; g++) begin
        m_cnt[g]  = 0;
        m_tick[g] = 0;
      end
      m_reg[0] = 0;
      m_reg[1] = 0;
    end else begin
      for (int g = 0; g < 6; g++) begin
        int  word, f, d, ratio;
        bit  en, hit;
        word = g / 3;
        f = (m_reg[word] >> (10 * (g % 3))) & 32'h3FF;
        d = f / 4;
        if (!ext_mode) begin
          en    = (f & 2) != 0;
          hit   = (f & 1) ? src_aux : src_cpu;
          ratio = 2 * d + 2;
        end else begin
          en = (f % 4) != 0;
          case (f % 4)
            1:       hit = src_aux2;
            2:       hit = src_cpu;
            3:       hit = src_aux;
            default: hit = 0;
          endcase
          ratio = m_reg[word][30] ? d + 1 : 2 * d + 2;
        end
        if (wr_en && int'(wr_addr) == word) begin
          m_cnt[g] = 0; m_tick[g] = 0;
        end else if (!en) begin
          m_cnt[g] = 0; m_tick[g] = 0;
        end else if (hit) begin
          m_cnt[g] = m_cnt[g] + 1;
          if (m_cnt[g] >= ratio) begin
            m_tick[g] = 1; m_cnt[g] = 0;
          end else begin
            m_tick[g] = 0;
          end
        end else begin
          m_tick[g] = 0;
        end
      end
      if (wr_en) m_reg[wr_addr] = wr_data & 32'h7FFF_FFFF;
    end
  end

  task automatic check32(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // One clock: compare outputs away from the edge, then drive the next inputs.
  task automatic step();
    logic [5:0] exp_t;
    @(negedge clk);
    for (int g = 0; g < 6; g++) exp_t[g] = m_tick[g];
    checks++;
    if (gen_tick !== exp_t) begin
      errors++;
      $display("FAIL %s gen_tick got %b expected %b", cur_req, gen_tick, exp_t);
    end
    checks++;
    if (rd_data !== m_reg[rd_addr]) begin
      errors++;
      $display("FAIL R2 rd_data[%0d] got %h expected %h", rd_addr, rd_data, m_reg[rd_addr]);
    end
    src_cpu  = ($urandom % 100) < dens;
    src_aux  = ($urandom % 100) < dens;
    src_aux2 = ($urandom % 100) < dens;
    rd_addr  = $urandom % 2;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] fld(input int d, input int code, input int slot);
    return 32'((d * 4 + code) << (10 * slot));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1;
    repeat (4) @(negedge clk);
    // R1: reset state of both words and all ticks
    rd_addr = 0; #1 check32(rd_data, 32'h0, "R1 word0 after reset");
    rd_addr = 1; #1 check32(rd_data, 32'h0, "R1 word1 after reset");
    check32({26'h0, gen_tick}, 32'h0, "R1 ticks after reset");
    rst_n = 1'b1;
    run(3);

    // R2: bit 31 is not stored
    cur_req = "R2";
    wr(0, 32'hFFFF_FFFF);
    rd_addr = 0; #1 check32(rd_data, 32'h7FFF_FFFF, "R2 bit31 masked");
    wr(1, 32'h1234_5678);
    rd_addr = 1; #1 check32(rd_data, 32'h1234_5678, "R2 word1 readback");
    wr(0, 0); wr(1, 0);

    // Legacy layout: R3 R4 R5 R10, scale bit set but ignored
    cur_req = "R3 R4 R5 R10";
    w0 = 32'h4000_0000 | fld(0, 2, 0) | fld(2, 3, 1) | fld(255, 2, 2);
    w1 = fld(1, 1, 0) | fld(5, 2, 1) | fld(3, 3, 2);
    wr(0, w0); wr(1, w1);
    run(3000);

    // R9: enable, disable and re-enable generators in word1
    cur_req = "R9";
    w1 = fld(1, 3, 0) | fld(5, 2, 1) | fld(3, 3, 2);
    wr(1, w1); run(400);
    wr(1, fld(1, 3, 0) | fld(5, 0, 1) | fld(3, 3, 2)); run(200);
    wr(1, w1); run(400);

    // R8: repeated rewrites restart the counts
    cur_req = "R8";
    for (int k = 0; k < 20; k++) begin
      wr(0, w0);
      run(20 + k);
    end

    // Extended layout: R6 R7, word0 unit steps, word1 even steps
    cur_req = "R6 R7 R10";
    wr(0, 0); wr(1, 0);
    ext_mode = 1'b1;
    wr(0, 32'h4000_0000 | fld(0, 1, 0) | fld(3, 2, 1) | fld(255, 3, 2));
    wr(1, fld(4, 0, 0) | fld(1, 1, 1) | fld(0, 3, 2));
    run(3000);
    cur_req = "R7";
    wr(1, 32'h4000_0000 | fld(4, 2, 0) | fld(1, 1, 1) | fld(0, 3, 2));
    run(600);
    cur_req = "R8 R5";
    ext_mode = 1'b0;
    wr(0, w0); wr(1, w1);
    run(600);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule